// File: doc/BRIEF.md
# UART General-Purpose Output Port

An eight-pin output port for a serial controller, written to over a byte-wide register bus. Software never writes the output latch directly. One address ORs a byte into the latch, a second address clears the latch bits marked by a byte, and a third address holds a configuration byte. In the default mode each pin shows the complement of its latch bit, so a cleared latch idles every pin high.

The configuration byte can switch some pins away from the latch to a signal from another part of the controller: a transmit or receive bit clock, the counter/timer output, or a receive-side or transmit-side interrupt. Every pin has a value output and a drive-enable output. A push-pull pin keeps drive-enable high. An open-drain pin drives a low value with drive-enable asserted when it signals, and it releases (drive-enable low) otherwise. The pad logic outside the block turns these two outputs into the real pin.

Top module: `uart_gpo_port`

## Requirements
- R1: During and directly after reset the latch and the configuration byte are zero. Every pin then has value 1 and drive-enable 1.
- R2: A write to address 0xE sets each latch bit whose data bit is 1 and leaves the other latch bits unchanged. The change is visible at the pins in the cycle after the write.
- R3: A write to address 0xF clears each latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R4: The latch and the configuration byte do not change when write-enable is low, or when a write goes to any address other than 0xD, 0xE and 0xF (0xD changes only the configuration, and 0xE and 0xF change only the latch).
- R5: Pins 0 and 1 always show the complement of their latch bit, push-pull. Pins 5 and 7 do the same for either value of configuration bits 5 and 7.
- R6: Pin 2 is selected by configuration bits [1:0], always push-pull. 00 gives the complement of latch bit 2, 01 the 16x transmit clock, 10 the 1x transmit clock and 11 the 1x receive clock. The clocks pass through without a register.
- R7: Pin 3 is selected by configuration bits [3:2]. 01 makes it open-drain, following the counter/timer output: value 0, with drive-enable equal to the complement of that output. 00, 10 and 11 give the complement of latch bit 3, push-pull.
- R8: When configuration bit 4 is 1, pin 4 is open-drain for the receive interrupt: value 0, with drive-enable equal to interrupt status bit 1 and no masking. When the bit is 0, pin 4 shows the complement of latch bit 4.
- R9: When configuration bit 6 is 1, pin 6 is open-drain for the transmit interrupt: value 0, with drive-enable equal to interrupt status bit 0 and no masking. When the bit is 0, pin 6 shows the complement of latch bit 6.
- R10: A write to address 0xD replaces the whole configuration byte. The new byte takes effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| isr_tx_rdy | input | 1 | Interrupt status bit 0, transmitter ready |
| isr_rx_rdy | input | 1 | Interrupt status bit 1, receiver ready or FIFO full |
| ct_out | input | 1 | Counter/timer output |
| txc_16x | input | 1 | 16x transmit clock |
| txc_1x | input | 1 | 1x transmit bit clock (free running) |
| rxc_1x | input | 1 | 1x receive bit clock (free running) |
| pin_val | output | DATA_W (8) | Value driven on each pin |
| pin_oe | output | DATA_W (8) | Drive-enable of each pin |

## Verification
The set and clear addresses are tried with every byte value, on top of a cleared latch and again on top of a partly set latch. The second pattern shows whether bits written as 0 keep their old value or lose it. Every one of the 256 configuration bytes is combined with all 64 combinations of the six side-band inputs, under two complementary latch patterns. This shows whether each pin picks the correct source and, for open-drain pins, whether drive-enable follows the source. Writes with write-enable low and writes to unrelated addresses show whether any stray decode reaches the registers.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

   localparam int PORT_W  = 8;
   localparam int PIN_CLK = 2;   // clock-select pin
   localparam int PIN_CT  = 3;   // counter/timer pin
   localparam int PIN_RXI = 4;   // receive interrupt pin
   localparam int PIN_TXI = 6;   // transmit interrupt pin

   typedef enum logic [1:0] {
      SEL_LATCH = 2'b00,
      SEL_ALT1  = 2'b01,
      SEL_ALT2  = 2'b10,
      SEL_ALT3  = 2'b11
   } pin_sel_e;

   // Which select codes route a side-band source to the pin.
   function automatic logic [3:0] alt_mask(input int pin);
      if (pin == PIN_CLK) return 4'b1110;
      if (pin == PIN_CT || pin == PIN_RXI || pin == PIN_TXI) return 4'b0010;
      return 4'b0000;
   endfunction

   // Which select codes make the pin open-drain.
   function automatic logic [3:0] od_mask(input int pin);
      if (pin == PIN_CT || pin == PIN_RXI || pin == PIN_TXI) return 4'b0010;
      return 4'b0000;
   endfunction

endpackage

// File: rtl/gpo_addr_dec.sv
module gpo_addr_dec #(
   parameter int          ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'hD,
   parameter logic [ADDR_W-1:0] SET_ADDR = 'hE,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 'hF
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              cfg_stb,
   output logic              set_stb,
   output logic              clr_stb
);
   if (CFG_ADDR == SET_ADDR || CFG_ADDR == CLR_ADDR || SET_ADDR == CLR_ADDR) begin : g_bad_map
      $error("gpo_addr_dec: register addresses must be distinct");
   end

   always_comb begin
      cfg_stb = wr_en && (wr_addr == CFG_ADDR);
      set_stb = wr_en && (wr_addr == SET_ADDR);
      clr_stb = wr_en && (wr_addr == CLR_ADDR);
   end
endmodule

// File: rtl/gpo_out_latch.sv
module gpo_out_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (set_stb) q <= q | mask;
      else if (clr_stb) q <= q & ~mask;
   end
endmodule

// File: rtl/gpo_cfg_reg.sv
module gpo_cfg_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/gpo_pin_mux.sv
module gpo_pin_mux
   import gpo_pkg::*;
#(
   parameter logic [3:0] ALT_MASK = 4'b0000,
   parameter logic [3:0] OD_MASK  = 4'b0000
) (
   input  logic       latch_bit,
   input  pin_sel_e   sel,
   input  logic [3:1] src,
   output logic       val,
   output logic       oe
);
   if (ALT_MASK[0] || ((OD_MASK & ~ALT_MASK) != 4'b0000)) begin : g_bad_mask
      $error("gpo_pin_mux: code 0 must be latch mode and open-drain codes must be alternates");
   end

   logic use_alt;
   logic use_od;
   logic src_bit;

   always_comb begin
      use_alt = ALT_MASK[sel];
      use_od  = OD_MASK[sel];
      src_bit = (sel == SEL_LATCH) ? 1'b0 : src[sel];
      if (!use_alt) begin
         val = ~latch_bit;
         oe  = 1'b1;
      end else if (use_od) begin
         val = 1'b0;
         oe  = ~src_bit;
      end else begin
         val = src_bit;
         oe  = 1'b1;
      end
   end
endmodule

// File: rtl/uart_gpo_port.sv
module uart_gpo_port
   import gpo_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = PORT_W,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'hD,
   parameter logic [ADDR_W-1:0] SET_ADDR = 'hE,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              isr_tx_rdy,
   input  logic              isr_rx_rdy,
   input  logic              ct_out,
   input  logic              txc_16x,
   input  logic              txc_1x,
   input  logic              rxc_1x,
   output logic [DATA_W-1:0] pin_val,
   output logic [DATA_W-1:0] pin_oe
);
   if (DATA_W != PORT_W) begin : g_bad_width
      $error("uart_gpo_port: the pin map needs an eight-bit port");
   end

   logic              cfg_stb, set_stb, clr_stb;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] cfg_q;

   gpo_addr_dec #(
      .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr),
      .cfg_stb(cfg_stb), .set_stb(set_stb), .clr_stb(clr_stb)
   );

   gpo_out_latch #(.W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
      .mask(wr_data), .q(latch_q)
   );

   gpo_cfg_reg #(.W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .ld(cfg_stb), .d(wr_data), .q(cfg_q)
   );

   for (genvar g = 0; g < DATA_W; g++) begin : g_pin
      pin_sel_e   sel;
      logic [3:1] src;

      if (g == PIN_CLK) begin : g_clk
         assign sel = pin_sel_e'(cfg_q[1:0]);
         assign src = {rxc_1x, txc_1x, txc_16x};
      end else if (g == PIN_CT) begin : g_ct
         assign sel = pin_sel_e'(cfg_q[3:2]);
         assign src = {2'b00, ct_out};
      end else if (g == PIN_RXI) begin : g_rxi
         assign sel = pin_sel_e'({1'b0, cfg_q[g]});
         assign src = {2'b00, ~isr_rx_rdy};
      end else if (g == PIN_TXI) begin : g_txi
         assign sel = pin_sel_e'({1'b0, cfg_q[g]});
         assign src = {2'b00, ~isr_tx_rdy};
      end else if (g > PIN_CT) begin : g_rsv
         assign sel = pin_sel_e'({1'b0, cfg_q[g]});
         assign src = 3'b000;
      end else begin : g_fixed
         assign sel = SEL_LATCH;
         assign src = 3'b000;
      end

      gpo_pin_mux #(
         .ALT_MASK(alt_mask(g)), .OD_MASK(od_mask(g))
      ) u_mux (
         .latch_bit(latch_q[g]), .sel(sel), .src(src),
         .val(pin_val[g]), .oe(pin_oe[g])
      );
   end
endmodule

// File: rtl/gpo_port_chk.sv
module gpo_port_chk #(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'hD,
   parameter logic [ADDR_W-1:0] SET_ADDR = 'hE,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 'hF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] latch_q,
   input logic [DATA_W-1:0] cfg_q,
   input logic              isr_tx_rdy,
   input logic              isr_rx_rdy,
   input logic              ct_out,
   input logic [DATA_W-1:0] pin_val,
   input logic [DATA_W-1:0] pin_oe
);
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SET_ADDR) |=>
         ((latch_q & $past(wr_data)) == $past(wr_data)) &&
         ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CLR_ADDR) |=>
         ((latch_q & $past(wr_data)) == '0) &&
         ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == SET_ADDR || wr_addr == CLR_ADDR)) |=> $stable(latch_q));

   p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == CFG_ADDR) |=> $stable(cfg_q));

   p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CFG_ADDR) |=> cfg_q == $past(wr_data));

   p_fixed_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ({pin_val[7], pin_val[5], pin_val[1:0]} ==
                ~{latch_q[7], latch_q[5], latch_q[1:0]}) &&
               ({pin_oe[7], pin_oe[5], pin_oe[1:0]} == 4'hF));

   p_pin2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[2] && ((cfg_q[1:0] == 2'b00) -> (pin_val[2] == !latch_q[2])));

   p_pin3_od_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3:2] == 2'b01) |-> (!pin_val[3] && pin_oe[3] == !ct_out));

   p_pin4_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[4] |-> (!pin_val[4] && pin_oe[4] == isr_rx_rdy));

   p_pin6_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[6] |-> (!pin_val[6] && pin_oe[6] == isr_tx_rdy));
endmodule

bind uart_gpo_port gpo_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CFG_ADDR(CFG_ADDR), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .latch_q(latch_q), .cfg_q(cfg_q), .isr_tx_rdy(isr_tx_rdy), .isr_rx_rdy(isr_rx_rdy),
   .ct_out(ct_out), .pin_val(pin_val), .pin_oe(pin_oe)
);

// File: tb/tb_uart_gpo_port.sv
`timescale 1ns/1ps
module tb_uart_gpo_port;
   localparam logic [3:0] A_CFG = 4'hD;
   localparam logic [3:0] A_SET = 4'hE;
   localparam logic [3:0] A_CLR = 4'hF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] aux = '0;
   logic [7:0] pin_val, pin_oe;
   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_latch = '0;
   logic [7:0] m_cfg = '0;

   always #2 clk = ~clk;

   uart_gpo_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .isr_tx_rdy(aux[0]), .isr_rx_rdy(aux[1]), .ct_out(aux[2]),
      .txc_16x(aux[3]), .txc_1x(aux[4]), .rxc_1x(aux[5]),
      .pin_val(pin_val), .pin_oe(pin_oe)
   );

   // expected {oe, val} from the requirements
   function automatic logic [15:0] model(logic [7:0] l, logic [7:0] c, logic [5:0] a);
      logic [7:0] v = ~l;
      logic [7:0] e = 8'hFF;
      case (c[1:0])
         2'b01: v[2] = a[3];
         2'b10: v[2] = a[4];
         2'b11: v[2] = a[5];
         default: ;
      endcase
      if (c[3:2] == 2'b01) begin v[3] = 1'b0; e[3] = ~a[2]; end
      if (c[4]) begin v[4] = 1'b0; e[4] = a[1]; end
      if (c[6]) begin v[6] = 1'b0; e[6] = a[0]; end
      return {e, v};
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {oe,val} actual %h expected %h (cfg %h latch %h aux %b)",
                  tag, act, exp, m_cfg, m_latch, aux);
      end
   endtask

   task automatic check_pins();
      logic [15:0] e = model(m_latch, m_cfg, aux);
      for (int p = 0; p < 8; p++) begin
         string tag;
         case (p)
            2: tag = "R6";
            3: tag = "R7";
            4: tag = "R8";
            6: tag = "R9";
            default: tag = "R5";
         endcase
         check(tag, {8'h00, pin_oe[p], 7'h00, pin_val[p]}, {8'h00, e[8+p], 7'h00, e[p]});
      end
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d, logic en = 1'b1);
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (en) begin
         if (a == A_CFG) m_cfg = d;
         if (a == A_SET) m_latch = m_latch | d;
         if (a == A_CLR) m_latch = m_latch & ~d;
      end
   endtask

   initial begin
      #600000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state with side-band inputs toggling
      repeat (3) @(negedge clk);
      check("R1", {pin_oe, pin_val}, 16'hFFFF);
      aux = 6'h3F; #1;
      check("R1", {pin_oe, pin_val}, 16'hFFFF);
      aux = 6'h00;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1", {pin_oe, pin_val}, 16'hFFFF);

      // R2 / R3: every byte through set and clear
      for (int i = 0; i < 256; i++) begin
         bus_write(A_CLR, 8'hFF);
         bus_write(A_SET, 8'(i));
         check("R2", {pin_oe, pin_val}, {8'hFF, ~8'(i)});
         bus_write(A_SET, 8'(i * 37 + 11));
         check("R2", {pin_oe, pin_val}, {8'hFF, ~(8'(i) | 8'(i * 37 + 11))});
         bus_write(A_CLR, 8'(i * 91 + 5));
         check("R3", {pin_oe, pin_val},
               {8'hFF, ~((8'(i) | 8'(i * 37 + 11)) & ~8'(i * 91 + 5))});
      end

      // R4: stray writes and disabled writes change nothing
      bus_write(A_CLR, 8'hFF);
      bus_write(A_SET, 8'h3C);
      aux = 6'b101010;
      for (int a = 0; a < 13; a++) begin
         bus_write(4'(a), 8'hFF);
         bus_write(4'(a), 8'h00);
      end
      bus_write(A_SET, 8'hC3, 1'b0);
      bus_write(A_CLR, 8'h3C, 1'b0);
      bus_write(A_CFG, 8'h5D, 1'b0);
      #1 check("R4", {pin_oe, pin_val}, model(8'h3C, 8'h00, aux));

      // R10: configuration byte fully replaced
      bus_write(A_CFG, 8'h5D);
      #1 check("R10", {pin_oe, pin_val}, model(8'h3C, 8'h5D, aux));
      bus_write(A_CFG, 8'h00);
      #1 check("R10", {pin_oe, pin_val}, model(8'h3C, 8'h00, aux));

      // R5-R9: every config byte against every side-band pattern
      for (int k = 0; k < 2; k++) begin
         bus_write(A_CLR, 8'hFF);
         bus_write(A_SET, k ? 8'h5A : 8'hA5);
         for (int c = 0; c < 256; c++) begin
            bus_write(A_CFG, 8'(c));
            for (int a = 0; a < 64; a++) begin
               aux = 6'(a);
               #0.5;
               check_pins();
            end
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule